// File: doc/BRIEF.md
# Word Store with Latched Address Register

This block is a small synchronous storage array of 16 words of 4 bits. No address is applied straight to the array. An internal address register picks the active word. That register takes a new value from a dedicated address input, and only on a rising clock edge at which the address-load strobe is high.

Both sides of an access use whatever address the register holds at that moment. A data write stores the write data into the selected word. The read output always shows the selected word, and there is no read strobe. To store value V at address A, a user needs two edges: the first loads A, and the second asserts the write strobe. A read needs only the load edge. The selected word appears just after that edge.

The address register and the array share one clock. Neither has a reset, so their contents are undefined until they are loaded.

Top module: `latched_addr_ram`

## Requirements
- R1: On a rising edge with addr_we_i = 1, the address register takes addr_i. Just after that edge, rdata_o shows the word at that address.
- R2: On a rising edge with addr_we_i = 0, the address register keeps its value. Changes on addr_i have no effect on rdata_o.
- R3: On a rising edge with we_i = 1, wdata_i is stored into the word selected by the address register. When that word stays selected, rdata_o shows the new value just after the edge.
- R4: On a rising edge with we_i = 0, no word changes, whatever the value of wdata_i.
- R5: A write changes only the selected word. All other words keep their values.
- R6: When addr_we_i and we_i are both 1 at the same edge, the write goes to the address held before that edge. At that same edge the register takes addr_i.
- R7: rdata_o depends only on the stored state and needs no read strobe. Between clock edges it does not change when the inputs change.
- R8: All 16 addresses (0 to 15) select distinct 4-bit words that can be stored independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the address register and the array |
| addr_i | input | 4 | New address, taken when addr_we_i is high |
| addr_we_i | input | 1 | Address-load strobe |
| wdata_i | input | 4 | Data to store |
| we_i | input | 1 | Data write strobe |
| rdata_o | output | 4 | Word selected by the address register |

## Verification
A wrong address register shows up on rdata_o at the first edge after a load, because the word shown is then not the expected one. A write that goes to the wrong word has two visible effects. It corrupts the selected value, which appears at once. It also corrupts another word, which appears only when that word is next selected. For that reason, the bench follows each write sweep with a readback of every address. A same-edge load and write that uses the new address instead of the old one is exposed by reading the old address afterwards.

// File: rtl/lar_pkg.sv
package lar_pkg;
  localparam int unsigned DEF_WORDS = 16;
  localparam int unsigned DEF_WIDTH = 4;
endpackage

// File: rtl/lar_addr_reg.sv
module lar_addr_reg #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          ld_i,
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  // intentionally no reset
  always_ff @(posedge clk_i) begin
    if (ld_i) addr_q <= addr_i;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/lar_word_array.sv
module lar_word_array #(
  parameter int unsigned WORDS = 16,
  parameter int unsigned WIDTH = 4,
  parameter int unsigned AW    = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [WORDS];
  logic [WORDS-1:0] hit;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign hit[g] = (sel_i == AW'(g));
    always_ff @(posedge clk_i) begin
      if (we_i && hit[g]) mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[sel_i];
endmodule

// File: rtl/latched_addr_ram.sv
module latched_addr_ram #(
  parameter int unsigned WORDS = lar_pkg::DEF_WORDS,
  parameter int unsigned WIDTH = lar_pkg::DEF_WIDTH,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             addr_we_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             we_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [AW-1:0] addr_q;

  lar_addr_reg #(.AW(AW)) u_addr (
    .clk_i  (clk_i),
    .ld_i   (addr_we_i),
    .addr_i (addr_i),
    .addr_o (addr_q)
  );

  // write uses pre-edge address, so a same-edge load targets the next access
  lar_word_array #(.WORDS(WORDS), .WIDTH(WIDTH), .AW(AW)) u_arr (
    .clk_i   (clk_i),
    .we_i    (we_i),
    .sel_i   (addr_q),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/lar_checker.sv
module lar_checker #(
  parameter int unsigned AW    = 4,
  parameter int unsigned WIDTH = 4
) (
  input logic             clk_i,
  input logic [AW-1:0]    addr_i,
  input logic             addr_we_i,
  input logic [WIDTH-1:0] wdata_i,
  input logic             we_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic [AW-1:0]    addr_q
);
  // no reset exists: arm once an address has been loaded
  logic armed = 1'b0;
  always_ff @(posedge clk_i) begin
    if (addr_we_i) armed <= 1'b1;
  end

  p_load_r1: assert property (@(posedge clk_i) disable iff (!armed)
    addr_we_i |=> addr_q == $past(addr_i));

  p_keep_addr_r2: assert property (@(posedge clk_i) disable iff (!armed)
    !addr_we_i |=> $stable(addr_q));

  p_write_seen_r3: assert property (@(posedge clk_i) disable iff (!armed)
    (we_i && !addr_we_i) |=> rdata_o == $past(wdata_i));

  p_idle_stable_r4: assert property (@(posedge clk_i) disable iff (!armed)
    (!we_i && !addr_we_i) |=> $stable(rdata_o));

  p_same_addr_r6: assert property (@(posedge clk_i) disable iff (!armed)
    (we_i && addr_we_i && addr_i == addr_q) |=> rdata_o == $past(wdata_i));
endmodule

bind latched_addr_ram lar_checker #(.AW(AW), .WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .addr_i    (addr_i),
  .addr_we_i (addr_we_i),
  .wdata_i   (wdata_i),
  .we_i      (we_i),
  .rdata_o   (rdata_o),
  .addr_q    (addr_q)
);

// File: tb/tb_latched_addr_ram.sv
`timescale 1ns/1ps
module tb_latched_addr_ram;
  logic       clk = 1'b0;
  logic [3:0] addr_i = '0;
  logic       addr_we_i = 1'b0;
  logic [3:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic [3:0] rdata_o;

  int n_run = 0;
  int n_fail = 0;
  logic [3:0] ref_mem [16];
  logic [3:0] ref_addr;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #2.5 clk = ~clk;

  latched_addr_ram dut (
    .clk_i(clk), .addr_i(addr_i), .addr_we_i(addr_we_i),
    .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata_o=%h expected %h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample 1 ns after the rising edge
  task automatic step(input logic aw, input logic [3:0] a, input logic w, input logic [3:0] d);
    @(negedge clk);
    addr_we_i = aw; addr_i = a; we_i = w; wdata_i = d;
    @(posedge clk);
    if (w) ref_mem[ref_addr] = d;
    if (aw) ref_addr = a;
    #1;
  endtask

  task automatic step_chk(input string req, input logic aw, input logic [3:0] a,
                          input logic w, input logic [3:0] d);
    step(aw, a, w, d);
    chk(req, rdata_o, ref_mem[ref_addr]);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // first load: contents unknown until written (R8 sweep)
    for (int a = 0; a < 16; a++) begin
      step(1'b1, 4'(a), 1'b0, 4'h0);
      step_chk("R3", 1'b0, 4'h0, 1'b1, 4'((a * 3 + 5) & 15));
    end
    for (int a = 0; a < 16; a++) begin
      step_chk("R1", 1'b1, 4'(a), 1'b0, 4'hF);
      chk("R8", rdata_o, 4'((a * 3 + 5) & 15));
    end
    // R5: rewrite even words only, then read all
    for (int a = 0; a < 16; a += 2) begin
      step(1'b1, 4'(a), 1'b0, 4'h0);
      step(1'b0, 4'h0, 1'b1, ~4'(a));
    end
    for (int a = 0; a < 16; a++) begin
      step(1'b1, 4'(a), 1'b0, 4'h0);
      chk("R5", rdata_o, (a % 2 == 0) ? ~4'(a) : 4'((a * 3 + 5) & 15));
    end
    // R2 / R7: address input moves without strobe
    step(1'b1, 4'd7, 1'b0, 4'h0);
    for (int a = 0; a < 16; a++) begin
      step_chk("R2", 1'b0, 4'(a), 1'b0, 4'(a));
      @(negedge clk);
      addr_i = ~4'(a); wdata_i = 4'(a);
      #1;
      chk("R7", rdata_o, ref_mem[4'd7]);
    end
    // R4: wdata toggles with we low
    for (int d = 0; d < 16; d++) step_chk("R4", 1'b0, 4'h0, 1'b0, 4'(d));
    chk("R4", rdata_o, 4'((7 * 3 + 5) & 15));
    // R6: simultaneous strobes, different address
    step(1'b1, 4'd3, 1'b0, 4'h0);
    step_chk("R6", 1'b1, 4'd9, 1'b1, 4'hA);
    chk("R6", rdata_o, 4'((9 * 3 + 5) & 15));
    step(1'b1, 4'd3, 1'b0, 4'h0);
    chk("R6", rdata_o, 4'hA);
    step(1'b1, 4'd9, 1'b0, 4'h0);
    chk("R6", rdata_o, 4'((9 * 3 + 5) & 15));
    // R6: same address on both
    step_chk("R6", 1'b1, 4'd9, 1'b1, 4'h6);
    chk("R6", rdata_o, 4'h6);
    // random mix (R1 R3 R6)
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step_chk("R1/R3/R6 random", lfsr[0], lfsr[7:4], lfsr[1], lfsr[11:8]);
    end
    for (int a = 0; a < 16; a++) step_chk("R5 final", 1'b1, 4'(a), 1'b0, 4'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule